// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral behind a 32-bit register port. Software sets a 4-bit interval code and an enable bit, then refreshes the watchdog by writing a restart command. Between refreshes a countdown advances by one step on each half-second tick strobe. If the countdown reaches zero while the watchdog and its reset output are both enabled, the block raises a system-reset request for one clock cycle. The countdown is one-shot: after it expires it stays at zero until software loads it again.

The `KEYED` parameter chooses between two variants. In the keyed variant a restart write takes effect only when it carries a 12-bit key. The reset-enable bit sits in a separate configuration register, and three plain storage registers sit beside it (interrupt enable, interrupt status and configuration). In the unkeyed variant every restart write takes effect, and the mode register holds the reset-enable bit as well as the interval code. The two variants place the interval code at different bit positions.

Reads are combinational from the address. Writes take effect on the clock edge at which `wr_en` is sampled high. The tick input is a one-cycle enable that the surrounding clock logic generates.

Top module: `kwd_top`

## Requirements
- R1: After reset every register reads zero, the countdown is stopped and `rst_req` is low.
- R2: Keyed map: interrupt enable at 0x00, interrupt status at 0x04, restart/control at 0x10, configuration at 0x14, mode at 0x18. Unkeyed map: control at 0x00, mode at 0x04. The control register and every unmapped offset read zero, and writes to unmapped offsets change nothing.
- R3: In the keyed variant a control write acts only if bits 12:1 equal 0xA57, so the word 0x000014AF is a valid restart. The unkeyed variant accepts any control write. A restart also needs bit 0 set.
- R4: A valid restart reloads the countdown from the interval map, using the code currently in the mode register, and starts it.
- R5: A mode write that takes mode bit 0 (enable) from 0 to 1 loads the countdown from the code being written. Any other mode write only stores the value and leaves the countdown running undisturbed.
- R6: The countdown decrements by one on each tick while it runs. On reaching zero it stops, and further ticks produce no more requests.
- R7: The interval code is mode bits 7:4 (keyed) or mode bits 6:3 (unkeyed). Reset-enable is configuration bit 0 (keyed) or mode bit 1 (unkeyed). Expiry raises `rst_req` only if the mode enable and the variant's reset-enable are both set.
- R8: Interval codes 0 to 11 load 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 ticks. Codes 12 to 15 leave the countdown stopped and unloaded.
- R9: `rst_req` is a registered pulse one cycle wide. It rises on the clock edge that samples the tick that takes the countdown to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one 32-bit word |
| addr | input | 8 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | Half-second enable strobe, one cycle wide |
| rst_req | output | 1 | System-reset request pulse |

## Verification
A write changes the register contents on the edge that samples `wr_en`, so the bench reads back at the next falling edge. A load also happens on that edge, so a tick issued after the write counts as the first decrement. `rst_req` appears one register stage after the edge that samples the final tick. The bench therefore drives each tick at a falling edge and samples the request at the following falling edge. It samples again one cycle later to confirm that the pulse has ended. An expiry is counted by the index of the tick that produced it, which matches the interval map exactly with no slack.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int CODE_W   = 4;
    localparam int CNT_W    = 6;
    localparam int KEY_W    = 12;
    localparam logic [KEY_W-1:0] RESTART_KEY = 12'hA57;
    localparam int NUM_CODES = 12;

    typedef struct packed {
        logic [DATA_W-1:0] irq_en;
        logic [DATA_W-1:0] irq_sta;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] mode;
    } reg_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             req;
    } cnt_state_t;

    function automatic logic [ADDR_W-1:0] ofs_ctrl(input bit keyed);
        return keyed ? 8'h10 : 8'h00;
    endfunction

    function automatic logic [ADDR_W-1:0] ofs_mode(input bit keyed);
        return keyed ? 8'h18 : 8'h04;
    endfunction

    localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IRQ_STA = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h14;

    function automatic int code_lsb(input bit keyed);
        return keyed ? 4 : 3;
    endfunction

    function automatic logic code_valid(input logic [CODE_W-1:0] code);
        return int'(code) < NUM_CODES;
    endfunction

    // half-second steps per interval code
    function automatic logic [CNT_W-1:0] code_ticks(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] t;
        if (code < 4'd6)
            t = (code == 4'd0) ? 6'd1 : CNT_W'({code, 1'b0});
        else if (code < 4'd12)
            t = CNT_W'((int'(code) - 3) * 4);
        else
            t = '0;
        return t;
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter bit KEYED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              load_o,
    output logic [CODE_W-1:0] load_code_o,
    output logic              wd_en_o,
    output logic              rst_en_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ofs_ctrl(KEYED);
    localparam logic [ADDR_W-1:0] MODE_A = ofs_mode(KEYED);
    localparam int                LSB    = code_lsb(KEYED);

    reg_state_t q, d;
    logic       key_ok;

    assign key_ok = KEYED ? (wr_data[KEY_W:1] == RESTART_KEY) : 1'b1;

    always_comb begin
        d           = q;
        load_o      = 1'b0;
        load_code_o = q.mode[LSB +: CODE_W];
        if (wr_en) begin
            if (addr == CTRL_A) begin
                if (key_ok && wr_data[0]) load_o = 1'b1;
            end else if (addr == MODE_A) begin
                d.mode = wr_data;
                if (wr_data[0] && !q.mode[0]) begin
                    load_o      = 1'b1;
                    load_code_o = wr_data[LSB +: CODE_W];
                end
            end else if (KEYED && addr == OFS_IRQ_EN) begin
                d.irq_en = wr_data;
            end else if (KEYED && addr == OFS_IRQ_STA) begin
                d.irq_sta = wr_data;
            end else if (KEYED && addr == OFS_CFG) begin
                d.cfg = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == MODE_A)                            rd_data = q.mode;
        else if (KEYED && addr == OFS_IRQ_EN)          rd_data = q.irq_en;
        else if (KEYED && addr == OFS_IRQ_STA)         rd_data = q.irq_sta;
        else if (KEYED && addr == OFS_CFG)             rd_data = q.cfg;
    end

    assign wd_en_o = q.mode[0];

    generate
        if (KEYED) begin : g_cfg_rsten
            assign rst_en_o = q.cfg[0];
        end else begin : g_mode_rsten
            assign rst_en_o = q.mode[1];
        end
    endgenerate
endmodule

// File: rtl/kwd_count.sv
module kwd_count
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              wd_en,
    input  logic              rst_en,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              rst_req
);
    cnt_state_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (load) begin
            if (code_valid(load_code)) begin
                d.count   = code_ticks(load_code);
                d.running = 1'b1;
            end else begin
                d.running = 1'b0;
            end
        end else if (q.running && tick) begin
            if (q.count == CNT_W'(1)) begin
                d.count   = '0;
                d.running = 1'b0;
                d.req     = wd_en && rst_en;
            end else begin
                d.count = q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count   = q.count;
    assign running = q.running;
    assign rst_req = q.req;
endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter bit KEYED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              rst_req
);
    logic              load_w;
    logic [CODE_W-1:0] code_w;
    logic              wd_en_w;
    logic              rst_en_w;
    logic [CNT_W-1:0]  count_w;
    logic              running_w;

    kwd_regs #(.KEYED(KEYED)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .load_o     (load_w),
        .load_code_o(code_w),
        .wd_en_o    (wd_en_w),
        .rst_en_o   (rst_en_w)
    );

    kwd_count u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load_w),
        .load_code(code_w),
        .wd_en    (wd_en_w),
        .rst_en   (rst_en_w),
        .count    (count_w),
        .running  (running_w),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
    import kwd_pkg::*;
#(
    parameter bit KEYED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic              rst_req,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              wd_en,
    input logic              rst_en
);
    localparam logic [ADDR_W-1:0] CTRL_A = ofs_ctrl(KEYED);
    localparam logic [ADDR_W-1:0] MODE_A = ofs_mode(KEYED);

    // R3: a control write with a wrong key leaves the countdown alone
    a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (KEYED && wr_en && addr == CTRL_A && wr_data[KEY_W:1] != RESTART_KEY && !tick)
        |=> ($stable(count) && $stable(running)));

    // R5: a mode write with enable already set does not reload
    a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MODE_A && wd_en && !tick)
        |=> ($stable(count) && $stable(running)));

    // R6: after a request the countdown is stopped at zero
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!running && count == '0));

    // R7: a request needs both enables
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wd_en && rst_en));

    // R8: the countdown never exceeds the largest interval
    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(32));

    // R9: one-cycle pulse, caused by a tick
    a_r9_width: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    a_r9_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick));
endmodule

bind kwd_top kwd_chk #(.KEYED(KEYED)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .tick   (tick),
    .rst_req(rst_req),
    .count  (count_w),
    .running(running_w),
    .wd_en  (wd_en_w),
    .rst_en (rst_en_w)
);

// File: tb/sim_kwd_top.sv
`timescale 1ns/1ps
module sim_kwd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        tick = 1'b0;
    logic        req0, req1;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] GOOD = 32'h0000_14AF;   // key 0xA57, bit0 set
    localparam logic [31:0] BAD  = 32'h0000_14AD;   // key 0xA56, bit0 set

    always #10 clk = ~clk;

    kwd_top #(.KEYED(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr0), .addr(addr),
        .wr_data(wdata), .rd_data(rd0), .tick(tick), .rst_req(req0));
    kwd_top #(.KEYED(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(wr1), .addr(addr),
        .wr_data(wdata), .rd_data(rd1), .tick(tick), .rst_req(req1));

    function automatic int exp_ticks(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 4;   3: return 6;
            4: return 8;   5: return 10;  6: return 12;  7: return 16;
            8: return 20;  9: return 24;  10: return 28; 11: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (sel) wr1 = 1'b1; else wr0 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = sel ? rd1 : rd0;
    endtask

    // issue n ticks; report index of first request and request count per DUT
    task automatic ticks(input int n, output int f0, output int n0, output int f1, output int n1,
                         output int wide);
        f0 = 0; n0 = 0; f1 = 0; n1 = 0; wide = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (req0 || req1) wide++;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (req0) begin n0++; if (f0 == 0) f0 = i; end
            if (req1) begin n1++; if (f1 == 0) f1 = i; end
        end
        @(negedge clk);
        if (req0 || req1) wide++;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a <= 8'h1C; a += 4) begin
            rd(0, 8'(a), v); check(v == 0, "R1 keyed reset read", v, 0);
        end
        rd(1, 8'h00, v); check(v == 0, "R1 unkeyed ctrl reset", v, 0);
        rd(1, 8'h04, v); check(v == 0, "R1 unkeyed mode reset", v, 0);
        check(!req0 && !req1, "R1 request low", {req0, req1}, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(0, 8'h00, 32'hA5A5_0001); rd(0, 8'h00, v); check(v == 32'hA5A5_0001, "R2 irq_en", v, 32'hA5A5_0001);
        wr(0, 8'h04, 32'h0000_0F0F); rd(0, 8'h04, v); check(v == 32'h0F0F, "R2 irq_sta", v, 32'h0F0F);
        wr(0, 8'h14, 32'h0000_0000); rd(0, 8'h14, v); check(v == 0, "R2 cfg", v, 0);
        wr(0, 8'h08, 32'hFFFF_FFFF); rd(0, 8'h08, v); check(v == 0, "R2 unmapped write", v, 0);
        rd(0, 8'h00, v); check(v == 32'hA5A5_0001, "R2 unmapped write no side effect", v, 32'hA5A5_0001);
        wr(0, 8'h10, GOOD); rd(0, 8'h10, v); check(v == 0, "R2 ctrl reads zero", v, 0);
        wr(1, 8'h10, 32'h1234); rd(1, 8'h10, v); check(v == 0, "R2 unkeyed unmapped", v, 0);
        wr(1, 8'h04, 32'h0000_0070); rd(1, 8'h04, v); check(v == 32'h70, "R2 unkeyed mode", v, 32'h70);
        wr(1, 8'h04, 32'h0); wr(0, 8'h18, 32'h0);
    endtask

    task automatic t_restart;
        int f0, n0, f1, n1, w;
        wr(0, 8'h14, 32'h1);
        wr(0, 8'h18, 32'h21);               // enable rising, code 2 -> 4 ticks
        ticks(2, f0, n0, f1, n1, w);
        check(n0 == 0, "R4 no early expiry", n0, 0);
        wr(0, 8'h10, GOOD);                 // reload to 4
        ticks(6, f0, n0, f1, n1, w);
        check(f0 == 4, "R4 restart reload tick", f0, 4);
        check(n0 == 1, "R6 single request", n0, 1);
        check(w == 0, "R9 pulse one cycle", w, 0);
        ticks(10, f0, n0, f1, n1, w);
        check(n0 == 0, "R6 no reload by itself", n0, 0);
    endtask

    task automatic t_badkey;
        int f0, n0, f1, n1, w;
        wr(0, 8'h10, BAD);
        ticks(8, f0, n0, f1, n1, w);
        check(n0 == 0, "R3 wrong key ignored", n0, 0);
        wr(0, 8'h10, GOOD & ~32'h1);        // good key, restart bit clear
        ticks(8, f0, n0, f1, n1, w);
        check(n0 == 0, "R3 restart bit needed", n0, 0);
    endtask

    task automatic t_mode_store;
        int f0, n0, f1, n1, w;
        wr(0, 8'h18, 32'h0);
        wr(0, 8'h18, 32'h31);               // code 3 -> 6 ticks
        ticks(3, f0, n0, f1, n1, w);
        wr(0, 8'h18, 32'h01);               // enable stays 1: store only
        ticks(5, f0, n0, f1, n1, w);
        check(f0 == 3, "R5 mode write no reload", f0, 3);
    endtask

    task automatic t_gating;
        int f0, n0, f1, n1, w;
        wr(0, 8'h14, 32'h0);
        wr(0, 8'h18, 32'h03);               // mode bit1 set but not the keyed rst-en
        wr(0, 8'h10, GOOD);
        ticks(3, f0, n0, f1, n1, w);
        check(n0 == 0, "R7 keyed cfg reset-enable clear", n0, 0);
        wr(0, 8'h14, 32'h1);
        wr(0, 8'h18, 32'h00);               // watchdog disabled
        wr(0, 8'h10, GOOD);
        ticks(3, f0, n0, f1, n1, w);
        check(n0 == 0, "R7 disabled no request", n0, 0);
    endtask

    task automatic t_invalid;
        int f0, n0, f1, n1, w;
        wr(0, 8'h18, 32'hC1);               // rising edge, code 12
        ticks(40, f0, n0, f1, n1, w);
        check(n0 == 0, "R8 invalid code on enable", n0, 0);
        wr(0, 8'h18, 32'h00);
        wr(0, 8'h18, 32'hB1);               // code 11
        ticks(5, f0, n0, f1, n1, w);
        wr(0, 8'h18, 32'hD1);               // store code 13
        wr(0, 8'h10, GOOD);                 // restart with invalid code stops
        ticks(40, f0, n0, f1, n1, w);
        check(n0 == 0, "R8 invalid code stops counter", n0, 0);
    endtask

    task automatic t_sweep;
        int f0, n0, f1, n1, w;
        for (int c = 0; c < 12; c++) begin
            wr(0, 8'h18, 32'h0);
            wr(0, 8'h18, 32'(c << 4) | 32'h1);
            ticks(exp_ticks(c) + 1, f0, n0, f1, n1, w);
            check(f0 == exp_ticks(c) && n0 == 1, $sformatf("R8 code %0d ticks", c), f0, exp_ticks(c));
        end
    endtask

    task automatic t_unkeyed;
        int f0, n0, f1, n1, w;
        wr(1, 8'h04, 32'h0B);               // en, rst-en bit1, code 1 -> 2 ticks
        ticks(1, f0, n0, f1, n1, w);
        wr(1, 8'h00, 32'h1);                // any restart accepted
        ticks(3, f0, n0, f1, n1, w);
        check(f1 == 2 && n1 == 1, "R3 unkeyed restart accepted", f1, 2);
        check(w == 0, "R9 unkeyed pulse width", w, 0);
        wr(1, 8'h04, 32'h0);
        wr(1, 8'h04, 32'h19);               // code 3 at bits 6:3 -> 6 ticks, rst-en clear
        ticks(8, f0, n0, f1, n1, w);
        check(n1 == 0, "R7 unkeyed rst-en clear", n1, 0);
        wr(1, 8'h04, 32'h0);
        wr(1, 8'h04, 32'h1B);
        ticks(7, f0, n0, f1, n1, w);
        check(f1 == 6, "R7 unkeyed code field", f1, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_restart;
        t_badkey;
        t_mode_store;
        t_gating;
        t_invalid;
        t_sweep;
        t_unkeyed;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule